// File: doc/BRIEF.md
# Parallel Slave Port

This block lets an external 8-bit bus master read and write a single data latch inside the chip. The master uses three active-low controls: chip select, read strobe and write strobe. These arrive with no relation to the internal clock. Each one passes through a two-stage synchronizer. An access is then recognised on the cycle in which chip select and a strobe are first seen low together.

An external write stores the bus value in the latch, marks the input side full and requests an interrupt. An external read puts the latch on the bus for as long as chip select and the read strobe are both low, and it also requests an interrupt. The internal processor uses a register-style port. Through it the processor loads the latch, takes the last external write, clears the interrupt and the overflow flag, and switches the block between slave-port mode and plain general-purpose output. In general-purpose mode the strobes have no effect, and an internal enable decides whether the latch drives the bus.

The external bus is split into an input, an output and an output enable, so the pad ring can build the tri-state buffer.

Top module: `pslv_port`

## Requirements
- R1: After reset the latch holds 0, in_full, out_full, overflow and irq are 0, slave_mode is 0, and ext_data_oe is 0 while gpio_oe is 0.
- R2: When cfg_we is high at a rising edge, slave_mode takes the value of cfg_slave from that edge onward. At other times it holds its value.
- R3: In slave mode, when chip select and write strobe become low together, the block detects the access after two synchronizer flops. At the third rising edge after the pins fall, the latch loads ext_data_i and in_full and irq are set.
- R4: An access fires once per entry into the combined-low condition. Holding the strobes low gives no further events. Entering slave mode while the strobes are already low gives no event.
- R5: In slave mode, ext_data_oe is high exactly while ext_cs_n and ext_rd_n are both low, following the pins with no clock delay, and ext_data_o then carries the latch. The detected start of a read sets irq.
- R6: host_wr_en loads host_wdata into the latch at the next edge in either mode. In slave mode it also sets out_full. out_full clears on the edge at which the synchronized read condition ends.
- R7: host_rd_en clears in_full at the next edge. An external write detected on the same edge wins, and in_full stays set.
- R8: An external write detected while in_full is set also sets overflow. overflow stays set until ovf_clr, and a new overflow on the same edge wins over the clear.
- R9: irq stays set until irq_clr. A new access on the same edge wins over the clear.
- R10: With slave_mode at 0, the strobes change neither the latch nor any flag, and ext_data_oe follows gpio_oe.
- R11: If an external write and host_wr_en fall on the same edge, the latch takes the external data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load strobe for the mode bit |
| cfg_slave | input | 1 | New mode bit value, 1 selects slave-port mode |
| slave_mode | output | 1 | Current mode bit |
| gpio_oe | input | 1 | Bus drive enable in general-purpose mode |
| host_wr_en | input | 1 | Internal write of the latch |
| host_wdata | input | 8 | Internal write data |
| host_rd_en | input | 1 | Internal read acknowledge, clears in_full |
| host_rdata | output | 8 | Latch contents |
| irq_clr | input | 1 | Clears irq |
| ovf_clr | input | 1 | Clears overflow |
| in_full | output | 1 | External write waiting for the internal side |
| out_full | output | 1 | Internal write not yet read by the master |
| overflow | output | 1 | Sticky: external write arrived while in_full was set |
| irq | output | 1 | Interrupt request, one per external access |
| ext_cs_n | input | 1 | External chip select, active low |
| ext_rd_n | input | 1 | External read strobe, active low |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_data_i | input | 8 | External bus, incoming value |
| ext_data_o | output | 8 | External bus, outgoing value |
| ext_data_oe | output | 1 | External bus drive enable |

## Verification
The bench runs a behavioural model next to the design and compares every output on every cycle. Writes with short and long strobe holds show the difference between one event per access and repeated firing. A back-to-back write pair without an internal read shows whether overflow is set, and a write with an internal read in between shows that it is not. A read strobe without chip select, strobes toggled with the mode bit clear, and the mode bit set while the strobes are already low each show whether the gating stops unwanted events. An internal write followed by an external read shows how out_full and the bus enable behave through a complete read.

// File: rtl/pslv_pkg.sv
package pslv_pkg;
  typedef struct packed {
    logic in_full;
    logic out_full;
    logic overflow;
    logic irq;
  } pslv_flags_t;

  typedef struct packed {
    logic wr_start;
    logic rd_start;
    logic rd_end;
  } pslv_evt_t;
endpackage

// File: rtl/pslv_sync.sv
module pslv_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pslv_detect.sv
module pslv_detect
  import pslv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      enable,
  input  logic      cs_s_n,
  input  logic      rd_s_n,
  input  logic      wr_s_n,
  output pslv_evt_t evt
);
  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q;

  // Combined-low conditions in the internal clock domain
  assign wr_act = ~cs_s_n & ~wr_s_n;
  assign rd_act = ~cs_s_n & ~rd_s_n;

  // History is tracked even in general-purpose mode, so enabling the
  // port while an access is already in progress produces no event.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
    end
  end

  assign evt.wr_start = enable & wr_act & ~wr_act_q;
  assign evt.rd_start = enable & rd_act & ~rd_act_q;
  assign evt.rd_end   = enable & ~rd_act & rd_act_q;
endmodule

// File: rtl/pslv_regs.sv
module pslv_regs
  import pslv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_slave,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_en,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  input  logic [DATA_W-1:0] ext_data_i,
  input  pslv_evt_t         evt,
  output logic              mode_q,
  output logic [DATA_W-1:0] latch_q,
  output pslv_flags_t       flags_q
);
  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else if (cfg_we) mode_q <= cfg_slave;
  end

  // External write has priority over the internal side
  always_ff @(posedge clk) begin
    if (rst) latch_q <= '0;
    else if (evt.wr_start) latch_q <= ext_data_i;
    else if (host_wr_en) latch_q <= host_wdata;
  end

  // Set conditions win over clears in every flag
  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      if (evt.wr_start) flags_q.in_full <= 1'b1;
      else if (host_rd_en) flags_q.in_full <= 1'b0;

      if (host_wr_en && mode_q) flags_q.out_full <= 1'b1;
      else if (evt.rd_end) flags_q.out_full <= 1'b0;

      if (evt.wr_start && flags_q.in_full) flags_q.overflow <= 1'b1;
      else if (ovf_clr) flags_q.overflow <= 1'b0;

      if (evt.wr_start || evt.rd_start) flags_q.irq <= 1'b1;
      else if (irq_clr) flags_q.irq <= 1'b0;
    end
  end
endmodule

// File: rtl/pslv_port.sv
module pslv_port
  import pslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_slave,
  output logic              slave_mode,
  input  logic              gpio_oe,
  input  logic              host_wr_en,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              host_rd_en,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              irq_clr,
  input  logic              ovf_clr,
  output logic              in_full,
  output logic              out_full,
  output logic              overflow,
  output logic              irq,
  input  logic              ext_cs_n,
  input  logic              ext_rd_n,
  input  logic              ext_wr_n,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic [DATA_W-1:0] ext_data_o,
  output logic              ext_data_oe
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  pslv_evt_t         evt;
  pslv_flags_t       flags;
  logic [DATA_W-1:0] latch;
  logic              mode;

  assign ctrl_raw = {ext_cs_n, ext_rd_n, ext_wr_n};

  pslv_sync #(
    .WIDTH  (CTRL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CTRL_W{1'b1}})
  ) i_sync (
    .clk(clk),
    .rst(rst),
    .d  (ctrl_raw),
    .q  (ctrl_s)
  );

  pslv_detect i_detect (
    .clk   (clk),
    .rst   (rst),
    .enable(mode),
    .cs_s_n(ctrl_s[2]),
    .rd_s_n(ctrl_s[1]),
    .wr_s_n(ctrl_s[0]),
    .evt   (evt)
  );

  pslv_regs #(.DATA_W(DATA_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_slave (cfg_slave),
    .host_wr_en(host_wr_en),
    .host_wdata(host_wdata),
    .host_rd_en(host_rd_en),
    .irq_clr   (irq_clr),
    .ovf_clr   (ovf_clr),
    .ext_data_i(ext_data_i),
    .evt       (evt),
    .mode_q    (mode),
    .latch_q   (latch),
    .flags_q   (flags)
  );

  // Bus drive follows the raw pins so data is valid during the strobe
  assign ext_data_oe = mode ? (~ext_cs_n & ~ext_rd_n) : gpio_oe;
  assign ext_data_o  = latch;

  assign slave_mode = mode;
  assign host_rdata = latch;
  assign in_full    = flags.in_full;
  assign out_full   = flags.out_full;
  assign overflow   = flags.overflow;
  assign irq        = flags.irq;
endmodule

// File: rtl/pslv_port_chk.sv
module pslv_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic              cfg_slave,
  input logic              slave_mode,
  input logic              host_wr_en,
  input logic              irq_clr,
  input logic              ovf_clr,
  input logic              in_full,
  input logic              out_full,
  input logic              overflow,
  input logic              irq,
  input logic              ext_cs_n,
  input logic              ext_data_oe,
  input logic [DATA_W-1:0] ext_data_o,
  input logic [DATA_W-1:0] host_rdata
);
  p_mode_load_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> slave_mode == $past(cfg_slave));

  p_full_irq_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_full) |-> irq);

  p_no_drive_r5: assert property (@(posedge clk) disable iff (rst)
    slave_mode && ext_cs_n |-> !ext_data_oe);

  p_bus_latch_r5: assert property (@(posedge clk) disable iff (rst)
    ext_data_oe |-> ext_data_o == host_rdata);

  p_out_full_r6: assert property (@(posedge clk) disable iff (rst)
    host_wr_en && slave_mode |=> out_full);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overflow && !ovf_clr |=> overflow);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (rst)
    irq && !irq_clr |=> irq);

  p_gpio_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !slave_mode |=> !$rose(in_full));
endmodule

bind pslv_port pslv_port_chk #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_we     (cfg_we),
  .cfg_slave  (cfg_slave),
  .slave_mode (slave_mode),
  .host_wr_en (host_wr_en),
  .irq_clr    (irq_clr),
  .ovf_clr    (ovf_clr),
  .in_full    (in_full),
  .out_full   (out_full),
  .overflow   (overflow),
  .irq        (irq),
  .ext_cs_n   (ext_cs_n),
  .ext_data_oe(ext_data_oe),
  .ext_data_o (ext_data_o),
  .host_rdata (host_rdata)
);

// File: tb/test_pslv_port.sv
`timescale 1ns/1ps
module test_pslv_port;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1;
  logic cfg_we = 0, cfg_slave = 0, gpio_oe = 0;
  logic host_wr_en = 0, host_rd_en = 0, irq_clr = 0, ovf_clr = 0;
  logic [W-1:0] host_wdata = '0, ext_data_i = '0;
  logic ext_cs_n = 1, ext_rd_n = 1, ext_wr_n = 1;
  logic slave_mode, in_full, out_full, overflow, irq, ext_data_oe;
  logic [W-1:0] host_rdata, ext_data_o;

  pslv_port #(.DATA_W(W), .SYNC_STAGES(2)) i_pslv_port (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slave(cfg_slave),
    .slave_mode(slave_mode), .gpio_oe(gpio_oe), .host_wr_en(host_wr_en),
    .host_wdata(host_wdata), .host_rd_en(host_rd_en), .host_rdata(host_rdata),
    .irq_clr(irq_clr), .ovf_clr(ovf_clr), .in_full(in_full),
    .out_full(out_full), .overflow(overflow), .irq(irq),
    .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n), .ext_wr_n(ext_wr_n),
    .ext_data_i(ext_data_i), .ext_data_o(ext_data_o), .ext_data_oe(ext_data_oe)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: pin history (combined-low seen at past edges)
  bit m_mode, m_in, m_out, m_ovf, m_irq;
  logic [W-1:0] m_latch;
  bit hw[3], hr[3];

  always @(posedge clk) begin : ref_model
    bit wev, rev, rend;
    if (rst) begin
      m_mode = 0; m_in = 0; m_out = 0; m_ovf = 0; m_irq = 0; m_latch = '0;
      for (int i = 0; i < 3; i++) begin hw[i] = 0; hr[i] = 0; end
    end else begin
      // Two synchronizer flops plus the history flop: event uses pins two
      // and three edges back
      wev  = m_mode && hw[1] && !hw[2];
      rev  = m_mode && hr[1] && !hr[2];
      rend = m_mode && !hr[1] && hr[2];
      if (wev) m_ovf = m_in ? 1'b1 : m_ovf;
      if (!(wev && m_in) && ovf_clr) m_ovf = 0;
      if (wev) m_latch = ext_data_i;
      else if (host_wr_en) m_latch = host_wdata;
      if (wev) m_in = 1; else if (host_rd_en) m_in = 0;
      if (host_wr_en && m_mode) m_out = 1; else if (rend) m_out = 0;
      if (wev || rev) m_irq = 1; else if (irq_clr) m_irq = 0;
      if (cfg_we) m_mode = cfg_slave;
      hw[2] = hw[1]; hw[1] = hw[0]; hw[0] = !ext_cs_n && !ext_wr_n;
      hr[2] = hr[1]; hr[1] = hr[0]; hr[0] = !ext_cs_n && !ext_rd_n;
    end
  end

  always @(posedge clk) begin : compare
    bit exp_oe;
    #1;
    if (!rst) begin
      exp_oe = m_mode ? (!ext_cs_n && !ext_rd_n) : gpio_oe;
      chk(slave_mode == m_mode, "R2 slave_mode", slave_mode, m_mode);
      chk(host_rdata == m_latch, "R3/R6/R11 latch", host_rdata, m_latch);
      chk(in_full == m_in, "R7 in_full", in_full, m_in);
      chk(out_full == m_out, "R6 out_full", out_full, m_out);
      chk(overflow == m_ovf, "R8 overflow", overflow, m_ovf);
      chk(irq == m_irq, "R9/R4 irq", irq, m_irq);
      chk(ext_data_oe == exp_oe, "R5/R10 ext_data_oe", ext_data_oe, exp_oe);
      if (exp_oe) chk(ext_data_o == m_latch, "R5 ext_data_o", ext_data_o, m_latch);
    end
  end

  task automatic pulse_cfg(input bit v);
    @(negedge clk); cfg_we = 1; cfg_slave = v; @(negedge clk); cfg_we = 0;
  endtask
  task automatic host_write(input logic [W-1:0] d);
    @(negedge clk); host_wr_en = 1; host_wdata = d; @(negedge clk); host_wr_en = 0;
  endtask
  task automatic host_read();
    @(negedge clk); host_rd_en = 1; @(negedge clk); host_rd_en = 0;
  endtask
  task automatic clr_irq();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask
  task automatic clr_ovf();
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
  endtask
  task automatic ext_write(input logic [W-1:0] d, input int hold);
    @(negedge clk); ext_data_i = d; ext_cs_n = 0; ext_wr_n = 0;
    repeat (hold) @(negedge clk);
    ext_cs_n = 1; ext_wr_n = 1;
    repeat (4) @(negedge clk);
  endtask
  task automatic ext_read(input int hold);
    @(negedge clk); ext_cs_n = 0; ext_rd_n = 0;
    repeat (hold) @(negedge clk);
    ext_cs_n = 1; ext_rd_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(host_rdata == 0, "R1 latch", host_rdata, 0);
    chk({in_full, out_full, overflow, irq} == 0, "R1 flags", {in_full, out_full, overflow, irq}, 0);
    chk(slave_mode == 0 && ext_data_oe == 0, "R1 mode/oe", {slave_mode, ext_data_oe}, 0);

    // General-purpose mode: strobes ignored, gpio_oe drives the bus
    ext_write(8'h11, 3);
    chk(in_full == 0 && irq == 0 && host_rdata == 0, "R10 strobes ignored", {in_full, irq, host_rdata}, 0);
    @(negedge clk); gpio_oe = 1;
    @(negedge clk); chk(ext_data_oe == 1, "R10 gpio_oe", ext_data_oe, 1);
    gpio_oe = 0;
    host_write(8'h22);
    chk(out_full == 0 && host_rdata == 8'h22, "R6 gpio host write", {out_full, host_rdata}, {1'b0, 8'h22});

    // Strobes already low when the mode is entered: no event
    @(negedge clk); ext_cs_n = 0; ext_wr_n = 0; ext_data_i = 8'h33;
    repeat (5) @(negedge clk);
    pulse_cfg(1);
    repeat (6) @(negedge clk);
    chk(in_full == 0 && irq == 0, "R4 mode entry while low", {in_full, irq}, 0);
    ext_cs_n = 1; ext_wr_n = 1;
    repeat (4) @(negedge clk);

    // Basic write, then internal read
    ext_write(8'hA5, 3);
    chk(host_rdata == 8'hA5 && in_full && irq, "R3 write", {in_full, irq, host_rdata}, {2'b11, 8'hA5});
    host_read();
    chk(in_full == 0, "R7 read clears", in_full, 0);
    clr_irq();

    // Long hold: a single event only
    @(negedge clk); ext_data_i = 8'h5A; ext_cs_n = 0; ext_wr_n = 0;
    repeat (6) @(negedge clk);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    repeat (10) @(negedge clk);
    chk(irq == 0, "R4 single fire", irq, 0);
    ext_cs_n = 1; ext_wr_n = 1;
    repeat (4) @(negedge clk);

    // Second write without internal read: overflow
    ext_write(8'hC3, 2);
    chk(overflow == 1 && host_rdata == 8'hC3, "R8 overflow set", {overflow, host_rdata}, {1'b1, 8'hC3});
    repeat (5) @(negedge clk);
    chk(overflow == 1, "R8 sticky", overflow, 1);
    clr_ovf(); host_read(); clr_irq();

    // Read strobe without chip select: nothing happens
    @(negedge clk); ext_rd_n = 0;
    repeat (6) @(negedge clk);
    chk(irq == 0 && ext_data_oe == 0, "R5 no cs", {irq, ext_data_oe}, 0);
    ext_rd_n = 1;

    // Internal write then full external read
    host_write(8'h3C);
    chk(out_full == 1, "R6 out_full set", out_full, 1);
    ext_read(5);
    chk(out_full == 0 && irq == 1, "R6/R5 read done", {out_full, irq}, 2'b01);
    clr_irq();

    // External write and internal write on the same edge
    @(negedge clk); ext_data_i = 8'h77; ext_cs_n = 0; ext_wr_n = 0;
    @(negedge clk); @(negedge clk);
    host_wr_en = 1; host_wdata = 8'h99;
    @(negedge clk); host_wr_en = 0;
    chk(host_rdata == 8'h77, "R11 collision", host_rdata, 8'h77);
    ext_cs_n = 1; ext_wr_n = 1;
    repeat (4) @(negedge clk);

    // Leave slave mode and check the strobes are ignored again
    pulse_cfg(0);
    host_read(); clr_irq();
    ext_write(8'hEE, 3);
    chk(in_full == 0 && irq == 0, "R10 ignored after exit", {in_full, irq}, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule